// File: doc/BRIEF.md
# Row-Latched Burst Memory Front End

This block fronts a slow memory array whose rows are 256 bits wide and split into four 64-bit words. Every array access loads the whole row into a row latch. That includes word reads, word writes, line reads and refreshes. The latch remembers which row it holds. When a later word access or burst line read names that row, the block serves it from the latch with no array delay.

A requester issues one transfer at a time on a request/ready handshake and selects the operation with a 2-bit code. Read data returns on a valid strobe that also carries the word index. A done pulse ends every transfer. With the done pulse the block reports how many cycles the transfer took and whether it was served from the latch. The array latency is a parameter.

A cycle count of N means the last result is visible N cycles after the clock edge that accepted the request. The block stays busy until the done pulse, and it ignores any request presented while it is busy.

Top module: `rowlat_top`

## Requirements
- R1: After reset, reqReady is 1 and rdValid, xferDone, rowHit and xferCycles are all 0. No row counts as latched.
- R2: The operation code on reqOp is 0 for word read, 1 for word write, 2 for line read and 3 for refresh. A word read whose row differs from the latched row returns the addressed word with rdWord equal to reqWord. It completes in LAT cycles with rowHit 0, and the row becomes the latched row.
- R3: A word read of the latched row returns the addressed word one cycle after acceptance, with xferCycles 1 and rowHit 1.
- R4: A word write to a row that is not latched completes in LAT cycles with rowHit 0. It stores the word in the array and leaves that row latched, including the new word.
- R5: A word write to the latched row completes in 1 cycle with rowHit 1. It updates both the array and the latch, so later reads return the new data.
- R6: A refresh takes LAT cycles, produces no rdValid and reports rowHit 0. It replaces the latch with the refreshed row, so a following read of that row is a hit and a read of the previously latched row is a miss.
- R7: A line read with reqBurst 1 on a row that is not latched returns words 0, 1, 2 and 3 in that order. Word 0 arrives LAT cycles after acceptance and each later word one cycle after the previous one, for LAT+3 cycles in total.
- R8: A line read with reqBurst 1 on the latched row returns words 0 to 3 on four consecutive cycles starting one cycle after acceptance, with xferCycles 4 and rowHit 1.
- R9: A line read with reqBurst 0 performs a separate array access for each word. Each word takes LAT cycles, for 4*LAT cycles in total, with rowHit 0 whether or not the row was latched.
- R10: While reqReady is 0 a presented request has no effect: the running transfer keeps its timing and the array is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | Operation code (see R2) |
| reqBurst | input | 1 | Line read streams from the latch after one array access when 1 |
| reqRow | input | RADDR_W | Row address |
| reqWord | input | 2 | Word index within the row |
| reqWrData | input | 64 | Write data for a word write |
| reqReady | output | 1 | Block idle; a request is accepted on this edge |
| rdValid | output | 1 | rdData carries a read word |
| rdWord | output | 2 | Index of the word on rdData |
| rdData | output | 64 | Read data |
| xferDone | output | 1 | One-cycle pulse ending a transfer |
| xferCycles | output | CYC_W | Cycles taken by the transfer just ended |
| rowHit | output | 1 | The transfer most recently accepted is served from the latch |

## Verification
The bench builds the block with four rows and an array latency of three cycles. With that setting the latency figures are 3 for a miss, 6 for a burst miss and 12 for a non-burst line. The small row count lets the bench sweep every word of every row through miss and hit writes, miss and hit reads, burst and non-burst lines, and refreshes that move the latch. It keeps a reference copy of the array and of the latched row to predict data, hit status and cycle counts.

// File: rtl/rowlat_pkg.sv
package rowlat_pkg;
  localparam int WORD_W = 64;
  localparam int ROW_W  = 256;
  localparam int WORDS  = ROW_W / WORD_W;
  localparam int IDX_W  = $clog2(WORDS);

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_LINE = 2'd2,
    OP_REF  = 2'd3
  } op_e;

  // strobes from the sequencer to the row datapath
  typedef struct packed {
    logic             capture;   // register request fields
    logic             hitWrite;  // write request word into array and latch
    logic             fill;      // load latch from array row of captured request
    logic             fillWrite; // merge captured write word during fill
    logic             emit;      // update read data register
    logic             emitFill;  // read data from freshly filled row
    logic [IDX_W-1:0] emitIdx;   // word to emit
  } strobe_t;
endpackage

// File: rtl/rowlat_datapath.sv
module rowlat_datapath
  import rowlat_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int RADDR_W = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [RADDR_W-1:0] reqRow,
  input  logic [IDX_W-1:0]   reqWord,
  input  logic [WORD_W-1:0]  reqWrData,
  output logic               latchHit,
  output logic [WORD_W-1:0]  rdData
);
  logic [ROW_W-1:0]   arrayMem [ROWS];
  logic [ROW_W-1:0]   latchData;
  logic [RADDR_W-1:0] latchRow;
  logic               latchValid;
  logic [RADDR_W-1:0] curRow;
  logic [IDX_W-1:0]   curWord;
  logic [WORD_W-1:0]  curData;
  logic [ROW_W-1:0]   fillRow;

  assign latchHit = latchValid && (latchRow == reqRow);

  always_comb begin
    fillRow = arrayMem[curRow];
    if (strb.fillWrite) fillRow[curWord*WORD_W +: WORD_W] = curData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) arrayMem[i] <= '0;
      latchData  <= '0;
      latchRow   <= '0;
      latchValid <= 1'b0;
      curRow     <= '0;
      curWord    <= '0;
      curData    <= '0;
      rdData     <= '0;
    end else begin
      if (strb.capture) begin
        curRow  <= reqRow;
        curWord <= reqWord;
        curData <= reqWrData;
      end
      if (strb.hitWrite) begin
        arrayMem[reqRow][reqWord*WORD_W +: WORD_W] <= reqWrData;
        latchData[reqWord*WORD_W +: WORD_W]        <= reqWrData;
      end
      if (strb.fill) begin
        latchData  <= fillRow;
        latchRow   <= curRow;
        latchValid <= 1'b1;
        if (strb.fillWrite) arrayMem[curRow] <= fillRow;
      end
      if (strb.emit) begin
        rdData <= strb.emitFill ? fillRow[strb.emitIdx*WORD_W +: WORD_W]
                                : latchData[strb.emitIdx*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/rowlat_ctrl.sv
module rowlat_ctrl
  import rowlat_pkg::*;
#(
  parameter int LAT   = 3,
  parameter int CYC_W = $clog2(4*LAT+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             reqBurst,
  input  logic [IDX_W-1:0] reqWord,
  input  logic             latchHit,
  output logic             reqReady,
  output strobe_t          strb,
  output logic             rdValid,
  output logic [IDX_W-1:0] rdWord,
  output logic             xferDone,
  output logic [CYC_W-1:0] xferCycles,
  output logic             rowHit
);
  localparam int WAIT_W = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS-1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_STREAM} state_e;

  state_e            state, stateN;
  op_e               curOp, reqOpE;
  logic              curBurst;
  logic [IDX_W-1:0]  curWordC, wordIdx, idxN, idxNow;
  logic [WAIT_W-1:0] waitCnt, waitN;
  logic [CYC_W-1:0]  cycCnt, cycNow;
  logic              accept, hitOk, emitNow, doneNow;

  assign reqOpE   = op_e'(reqOp);
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign hitOk    = latchHit && ((reqOpE == OP_RD) || (reqOpE == OP_WR) ||
                                 ((reqOpE == OP_LINE) && reqBurst));
  assign cycNow   = (state == ST_IDLE) ? CYC_W'(1) : cycCnt + CYC_W'(1);

  always_comb begin
    strb    = '0;
    stateN  = state;
    waitN   = waitCnt;
    idxN    = wordIdx;
    idxNow  = wordIdx;
    emitNow = 1'b0;
    doneNow = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        strb.capture = 1'b1;
        if (hitOk) begin
          case (reqOpE)
            OP_RD: begin
              strb.emit = 1'b1; strb.emitIdx = reqWord;
              emitNow = 1'b1; idxNow = reqWord; doneNow = 1'b1;
            end
            OP_WR: begin
              strb.hitWrite = 1'b1; doneNow = 1'b1;
            end
            default: begin
              strb.emit = 1'b1; strb.emitIdx = '0;
              emitNow = 1'b1; idxNow = '0;
              idxN = IDX_W'(1); stateN = ST_STREAM;
            end
          endcase
        end else begin
          stateN = ST_ACCESS;
          waitN  = WAIT_W'(LAT-2);
          idxN   = '0;
        end
      end
      ST_ACCESS: begin
        if (waitCnt != '0) begin
          waitN = waitCnt - WAIT_W'(1);
        end else begin
          strb.fill      = 1'b1;
          strb.fillWrite = (curOp == OP_WR);
          case (curOp)
            OP_RD: begin
              strb.emit = 1'b1; strb.emitFill = 1'b1; strb.emitIdx = curWordC;
              emitNow = 1'b1; idxNow = curWordC; doneNow = 1'b1; stateN = ST_IDLE;
            end
            OP_LINE: begin
              strb.emit = 1'b1; strb.emitFill = 1'b1; strb.emitIdx = wordIdx;
              emitNow = 1'b1; idxNow = wordIdx;
              idxN = wordIdx + IDX_W'(1);
              if (curBurst) begin
                stateN = ST_STREAM;
              end else if (wordIdx == LAST_IDX) begin
                doneNow = 1'b1; stateN = ST_IDLE;
              end else begin
                waitN = WAIT_W'(LAT-1);
              end
            end
            default: begin
              doneNow = 1'b1; stateN = ST_IDLE;
            end
          endcase
        end
      end
      default: begin
        strb.emit = 1'b1; strb.emitIdx = wordIdx;
        emitNow = 1'b1; idxNow = wordIdx;
        idxN = wordIdx + IDX_W'(1);
        if (wordIdx == LAST_IDX) begin
          doneNow = 1'b1; stateN = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      curOp      <= OP_RD;
      curBurst   <= 1'b0;
      curWordC   <= '0;
      wordIdx    <= '0;
      waitCnt    <= '0;
      cycCnt     <= '0;
      rdValid    <= 1'b0;
      rdWord     <= '0;
      xferDone   <= 1'b0;
      xferCycles <= '0;
      rowHit     <= 1'b0;
    end else begin
      state    <= stateN;
      waitCnt  <= waitN;
      wordIdx  <= idxN;
      cycCnt   <= cycNow;
      rdValid  <= emitNow;
      rdWord   <= idxNow;
      xferDone <= doneNow;
      if (doneNow) xferCycles <= cycNow;
      if (accept) begin
        curOp    <= reqOpE;
        curBurst <= reqBurst;
        curWordC <= reqWord;
        rowHit   <= hitOk;
      end
    end
  end
endmodule

// File: rtl/rowlat_top.sv
module rowlat_top
  import rowlat_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int LAT  = 3,
  localparam int RADDR_W = $clog2(ROWS),
  localparam int CYC_W   = $clog2(4*LAT+1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic               reqBurst,
  input  logic [RADDR_W-1:0] reqRow,
  input  logic [IDX_W-1:0]   reqWord,
  input  logic [WORD_W-1:0]  reqWrData,
  output logic               reqReady,
  output logic               rdValid,
  output logic [IDX_W-1:0]   rdWord,
  output logic [WORD_W-1:0]  rdData,
  output logic               xferDone,
  output logic [CYC_W-1:0]   xferCycles,
  output logic               rowHit
);
  strobe_t strb;
  logic    latchHit;

  rowlat_ctrl #(.LAT(LAT), .CYC_W(CYC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBurst(reqBurst), .reqWord(reqWord), .latchHit(latchHit),
    .reqReady(reqReady), .strb(strb), .rdValid(rdValid), .rdWord(rdWord),
    .xferDone(xferDone), .xferCycles(xferCycles), .rowHit(rowHit)
  );

  rowlat_datapath #(.ROWS(ROWS), .RADDR_W(RADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .reqRow(reqRow), .reqWord(reqWord),
    .reqWrData(reqWrData), .latchHit(latchHit), .rdData(rdData)
  );
endmodule

// File: rtl/rowlat_chk.sv
module rowlat_chk #(
  parameter int LAT   = 3,
  parameter int CYC_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqOp,
  input logic             reqBurst,
  input logic             reqReady,
  input logic             rdValid,
  input logic             xferDone,
  input logic [CYC_W-1:0] xferCycles,
  input logic             rowHit
);
  // R3
  single_cycle_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferCycles == CYC_W'(1)) |-> rowHit);

  // R2
  miss_not_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !rowHit) |-> (xferCycles >= CYC_W'(LAT)));

  // R6
  refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd3) |=> (!reqReady && !rdValid && !rowHit));

  // R7
  burst_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd2 && reqBurst) |=> !reqReady);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> reqReady);
endmodule

bind rowlat_top rowlat_chk #(.LAT(LAT), .CYC_W(CYC_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .reqBurst(reqBurst), .reqReady(reqReady), .rdValid(rdValid),
  .xferDone(xferDone), .xferCycles(xferCycles), .rowHit(rowHit)
);

// File: tb/rowlat_top_test.sv
`timescale 1ns/1ps
module rowlat_top_test;
  localparam int ROWS    = 4;
  localparam int LAT     = 3;
  localparam int RADDR_W = $clog2(ROWS);
  localparam int CYC_W   = $clog2(4*LAT+1);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic [1:0]         reqOp = '0;
  logic               reqBurst = 1'b0;
  logic [RADDR_W-1:0] reqRow = '0;
  logic [1:0]         reqWord = '0;
  logic [63:0]        reqWrData = '0;
  logic               reqReady, rdValid, xferDone, rowHit;
  logic [1:0]         rdWord;
  logic [63:0]        rdData;
  logic [CYC_W-1:0]   xferCycles;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] mMem [ROWS][4];
  bit          mValid = 1'b0;
  int          mRow = 0;

  always #4 clk = ~clk;

  rowlat_top #(.ROWS(ROWS), .LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBurst(reqBurst), .reqRow(reqRow), .reqWord(reqWord),
    .reqWrData(reqWrData), .reqReady(reqReady), .rdValid(rdValid),
    .rdWord(rdWord), .rdData(rdData), .xferDone(xferDone),
    .xferCycles(xferCycles), .rowHit(rowHit)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int r, input int w, input int salt);
    return {16'(r), 16'(w), 32'(salt)} ^ 64'h3C96_0F0F_A5A5_1E2D;
  endfunction

  task automatic xfer(input int op, input int row, input int wd, input bit burst,
                      input logic [63:0] data, input bit intrude, input string extra);
    bit    hit;
    int    expCyc, expWords, n, got;
    bit    seenDone;
    string tag;
    hit = mValid && (mRow == row) && (op == 0 || op == 1 || (op == 2 && burst));
    case (op)
      0: begin tag = hit ? "R3" : "R2"; expCyc = hit ? 1 : LAT; expWords = 1; end
      1: begin tag = hit ? "R5" : "R4"; expCyc = hit ? 1 : LAT; expWords = 0; end
      2: begin
        if (burst) begin tag = hit ? "R8" : "R7"; expCyc = hit ? 4 : LAT + 3; end
        else begin tag = "R9"; expCyc = 4 * LAT; end
        expWords = 4;
      end
      default: begin tag = "R6"; expCyc = LAT; expWords = 0; end
    endcase
    tag = {tag, extra};
    @(negedge clk);
    chk(reqReady == 1'b1, tag, "ready before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqOp = 2'(op); reqRow = RADDR_W'(row);
    reqWord = 2'(wd); reqBurst = burst; reqWrData = data;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1; got = 0; seenDone = 1'b0;
    for (int it = 0; it < 64; it++) begin
      if (intrude && n == 1) begin
        reqValid = 1'b1; reqOp = 2'd1; reqRow = RADDR_W'((row + 1) % ROWS);
        reqWord = 2'd0; reqWrData = ~data;
      end
      if (intrude && n == 2) reqValid = 1'b0;
      if (rdValid) begin
        int idx;
        idx = (op == 0) ? wd : got;
        chk(rdWord == 2'(idx), tag, "word index", 64'(rdWord), 64'(idx));
        chk(rdData == mMem[row][idx], tag, "read data", rdData, mMem[row][idx]);
        got++;
      end
      if (xferDone) begin seenDone = 1'b1; break; end
      @(negedge clk);
      n++;
    end
    chk(seenDone, tag, "done seen", 64'(seenDone), 64'd1);
    chk(n == expCyc, tag, "done cycle", 64'(n), 64'(expCyc));
    chk(xferCycles == CYC_W'(expCyc), tag, "reported cycles", 64'(xferCycles), 64'(expCyc));
    chk(rowHit == hit, tag, "row hit", 64'(rowHit), 64'(hit));
    chk(got == expWords, tag, "word count", 64'(got), 64'(expWords));
    if (op == 1) mMem[row][wd] = data;
    mValid = 1'b1;
    mRow = row;
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < 4; w++) mMem[r][w] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", "reqReady", 64'(reqReady), 64'd1);
    chk(rdValid == 1'b0, "R1", "rdValid", 64'(rdValid), 64'd0);
    chk(xferDone == 1'b0, "R1", "xferDone", 64'(xferDone), 64'd0);
    chk(rowHit == 1'b0, "R1", "rowHit", 64'(rowHit), 64'd0);
    chk(xferCycles == '0, "R1", "xferCycles", 64'(xferCycles), 64'd0);

    // R4 / R5: miss then hit writes over every word of every row
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < 4; w++) xfer(1, r, w, 1'b0, pat(r, w, 1), 1'b0, "");
    // R2 / R3: miss then hit reads
    for (int r = ROWS - 1; r >= 0; r--)
      for (int w = 3; w >= 0; w--) xfer(0, r, w, 1'b0, '0, 1'b0, "");
    // R5 overwrite of latched row then hit read back
    for (int w = 0; w < 4; w++) xfer(1, 0, w, 1'b0, pat(0, w, 7), 1'b0, "");
    for (int w = 0; w < 4; w++) xfer(0, 0, w, 1'b0, '0, 1'b0, "_R5");
    // R6: refresh moves the latch
    for (int r = 0; r < ROWS; r++) begin
      xfer(3, r, 0, 1'b0, '0, 1'b0, "");
      xfer(0, r, r % 4, 1'b0, '0, 1'b0, "_R6");
      xfer(3, (r + 1) % ROWS, 0, 1'b0, '0, 1'b0, "");
      xfer(0, r, 1, 1'b0, '0, 1'b0, "_R6");
    end
    // R7 / R8: burst lines, miss then hit
    for (int r = 0; r < ROWS; r++) begin
      xfer(2, r, 0, 1'b1, '0, 1'b0, "");
      xfer(2, r, 0, 1'b1, '0, 1'b0, "");
    end
    // R9: non-burst lines on a latched and an unlatched row
    for (int r = 0; r < ROWS; r++) begin
      xfer(2, r, 0, 1'b0, '0, 1'b0, "");
      xfer(2, r, 0, 1'b0, '0, 1'b0, "");
    end
    // R10: write presented while busy must be ignored
    xfer(0, 2, 1, 1'b0, pat(9, 9, 9), 1'b1, "_R10");
    xfer(0, 3, 0, 1'b0, '0, 1'b0, "_R10");
    xfer(2, 3, 0, 1'b1, pat(8, 8, 8), 1'b1, "_R10");
    xfer(0, 0, 0, 1'b0, '0, 1'b0, "_R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule